// File: doc/BRIEF.md
# Speed-Mode PHY Reconfiguration Sequencer

This block rewrites the settings of a storage-card I/O PHY whenever the host switches the bus clock. A single request strobe brings in three values: a timing-mode code, a bus clock code and a pad drive type. The block uses a fixed per-mode table to choose the mode-control word and the input and output tap delays. It also decides whether the pad control register needs a read-modify-write and whether the DLL takes part. It then issues the matching register writes on a simple request/acknowledge port to an external register bridge.

For every mode except legacy, the sequence ends by stopping the DLL, restarting it with a frequency select taken from the clock code, and polling the DLL status until the ready bit appears. A bounded poll window turns a DLL that never locks into a sticky error flag. A request that carries the same clock code as the last applied one is dropped with no PHY traffic. A request that arrives while a sequence is running waits in a single slot, where a later request replaces an earlier one, and runs once the current sequence ends.

Top module: `phy_speed_sequencer`

## Requirements
- R1: A `req_valid` strobe with a clock code not yet applied raises `busy` on the next cycle. `busy` stays high through the sequence, which ends with a one-cycle `done` pulse. `busy` is low the cycle after `done` when nothing is waiting.
- R2: The first access of each sequence writes the mode word to address 0x11. Mode codes and words: 0 legacy → 0x04, 1 high speed → 0x00, 2 HS200 → 0x00, 3 DDR50 → 0x08, 4 HS400 → 0x02, 5 enhanced strobe → 0x01.
- R3: Only for HS200 and HS400, address 0x01 is read next. It is then written back as the value read ORed with the drive type shifted left by 2.
- R4: The output tap register 0x0D gets (tap << 1) | 1, with tap 3 for high speed, 2 for HS200 and 1 for DDR50, HS400 and enhanced strobe. Legacy writes 0x00.
- R5: The input tap register 0x0C, written right after 0x0D, gets (tap << 1) | 1, with tap 2 for high speed, 0xA for HS400 and 0 for DDR50 and enhanced strobe. HS200 and legacy write 0x00.
- R6: Every mode except legacy then writes 0x08 to the DLL trim register 0x12. Legacy skips this write.
- R7: The DLL register 0x00 is then written 0x00. Except in legacy, a second write follows with (fs << 5) | 0x08. The clock code maps to fs as 0 (200 MHz) → 0, 1 (100 MHz) → 2, 2 (50 MHz) → 1 and 3 (other) → 0.
- R8: After that write, address 0x00 is read repeatedly until a read returns bit 4 set. `done` then pulses with `dll_err` low, and no further reads are made.
- R9: If bit 4 has not been seen once POLL_LIMIT cycles of polling have passed, the sequence ends with `done` and `dll_err` rises with it, with no retry. `dll_err` holds until the next sequence starts.
- R10: A request whose clock code equals the last applied code makes no PHY access and gives no `done`. Before the first applied request, no code counts as applied.
- R11: A request that arrives while `busy` is high is kept, and the latest such request replaces earlier ones. It starts after the current `done`.
- R12: Mode codes 6 and 7 make no PHY access and give no `done`, but their clock code is recorded as applied.
- R13: `phy_req` stays high with `phy_wr`, `phy_addr` and `phy_wdata` unchanged until the cycle in which `phy_ack` is high. Each acknowledged cycle completes exactly one access.
- R14: After reset `busy`, `done`, `phy_req` and `dll_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle strobe for a clock/mode change |
| req_mode | input | 3 | Timing-mode code (0..5 valid) |
| req_clksel | input | 2 | Bus clock code |
| req_drive | input | DRV_W | Pad drive type |
| phy_req | output | 1 | PHY register access request |
| phy_wr | output | 1 | 1 = write, 0 = read |
| phy_addr | output | 8 | PHY register address |
| phy_wdata | output | 8 | Write data |
| phy_ack | input | 1 | Access complete |
| phy_rdata | input | 8 | Read data, valid with `phy_ack` |
| busy | output | 1 | A sequence is running or waiting |
| done | output | 1 | One-cycle end-of-sequence pulse |
| dll_err | output | 1 | DLL did not report ready in time |

## Verification
`busy` is due one cycle after the request strobe, since the request first goes into the waiting slot. The first PHY access appears one cycle after that. Each access finishes in the cycle its acknowledge is seen, and the next access is presented in the following cycle. `done` follows the final acknowledge by one cycle, and `dll_err` changes in that same cycle. The bench drives inputs and acknowledges and samples every output at falling edges, so each value it reads has settled from the preceding rising edge. It checks each sequence against an expected access list that it builds from the mode and clock tables alone.

// File: rtl/phycfg_pkg.sv
// Package: shared constants, types and table helpers for the PHY speed-mode
// sequencer. Assumes an 8-bit PHY register space with 8-bit data.
package phycfg_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 8;
    localparam int CLKSEL_W = 2;
    localparam int MODE_W   = 3;
    localparam int TAP_W    = DATA_W - 1;

    localparam logic [ADDR_W-1:0] A_DLL  = 8'h00;
    localparam logic [ADDR_W-1:0] A_PAD  = 8'h01;
    localparam logic [ADDR_W-1:0] A_ITAP = 8'h0C;
    localparam logic [ADDR_W-1:0] A_OTAP = 8'h0D;
    localparam logic [ADDR_W-1:0] A_MODE = 8'h11;
    localparam logic [ADDR_W-1:0] A_TRIM = 8'h12;

    localparam logic [DATA_W-1:0] TRIM_WORD = 8'h08;
    localparam logic [DATA_W-1:0] DLL_ON    = 8'h08;
    localparam int                RDY_BIT   = 4;
    localparam int                DRV_SHIFT = 2;

    typedef enum logic [MODE_W-1:0] {
        TM_LEGACY  = 3'd0,
        TM_HISPEED = 3'd1,
        TM_HS200   = 3'd2,
        TM_DDR     = 3'd3,
        TM_HS400   = 3'd4,
        TM_ESTROBE = 3'd5
    } timing_e;

    typedef struct packed {
        logic [DATA_W-1:0] mode_word;
        logic [TAP_W-1:0]  otap;
        logic [TAP_W-1:0]  itap;
        logic              otap_en;
        logic              itap_en;
        logic              pad_adj;
        logic              dll_used;
    } mode_cfg_t;

    // Map the bus clock code to the DLL frequency select.
    function automatic logic [2:0] freqsel(input logic [CLKSEL_W-1:0] code);
        case (code)
            2'd1:    freqsel = 3'd2;
            2'd2:    freqsel = 3'd1;
            default: freqsel = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/phycfg_mode_table.sv
// Module: per-mode setting lookup. Purely combinational; an unknown code
// returns an all-zero entry and drops `known`.
module phycfg_mode_table
    import phycfg_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output mode_cfg_t         cfg,
    output logic              known
);

    // Select the fixed settings for the requested timing mode.
    always_comb begin
        cfg   = '0;
        known = 1'b1;
        case (mode)
            TM_LEGACY: begin
                cfg.mode_word = 8'h04;
            end
            TM_HISPEED: begin
                cfg.otap = 7'd3; cfg.otap_en = 1'b1;
                cfg.itap = 7'd2; cfg.itap_en = 1'b1;
                cfg.dll_used = 1'b1;
            end
            TM_HS200: begin
                cfg.otap = 7'd2; cfg.otap_en = 1'b1;
                cfg.pad_adj = 1'b1; cfg.dll_used = 1'b1;
            end
            TM_DDR: begin
                cfg.mode_word = 8'h08;
                cfg.otap = 7'd1; cfg.otap_en = 1'b1;
                cfg.itap_en = 1'b1; cfg.dll_used = 1'b1;
            end
            TM_HS400: begin
                cfg.mode_word = 8'h02;
                cfg.otap = 7'd1;  cfg.otap_en = 1'b1;
                cfg.itap = 7'hA;  cfg.itap_en = 1'b1;
                cfg.pad_adj = 1'b1; cfg.dll_used = 1'b1;
            end
            TM_ESTROBE: begin
                cfg.mode_word = 8'h01;
                cfg.otap = 7'd1; cfg.otap_en = 1'b1;
                cfg.itap_en = 1'b1; cfg.dll_used = 1'b1;
            end
            default: known = 1'b0;
        endcase
    end

endmodule

// File: rtl/phycfg_req_slot.sv
// Module: single waiting slot for change requests. A new strobe overwrites
// the slot; a pop empties it unless a strobe lands in the same cycle.
module phycfg_req_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic         valid,
    output logic [W-1:0] dout
);

    // Hold the newest request until the sequencer consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            dout  <= '0;
        end else if (set) begin
            valid <= 1'b1;
            dout  <= din;
        end else if (pop) begin
            valid <= 1'b0;
        end
    end

endmodule

// File: rtl/phycfg_poll_timer.sv
// Module: poll window counter. Counts cycles while `run` is high, saturates
// at LIMIT and flags `expired` there; clears whenever `run` is low.
module phycfg_poll_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Count polling cycles up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  cnt <= '0;
        else if (cnt != LIM) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == LIM);

endmodule

// File: rtl/phy_speed_sequencer.sv
// Module: top of the speed-mode PHY sequencer. Takes a change request,
// drops it when the clock code is already applied, otherwise walks the
// register write list for the mode and polls DLL ready.
// Assumes the bridge holds phy_ack high for one cycle per access.
module phy_speed_sequencer
    import phycfg_pkg::*;
#(
    parameter int POLL_LIMIT = 64,
    parameter int DRV_W      = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [MODE_W-1:0]   req_mode,
    input  logic [CLKSEL_W-1:0] req_clksel,
    input  logic [DRV_W-1:0]    req_drive,
    output logic                phy_req,
    output logic                phy_wr,
    output logic [ADDR_W-1:0]   phy_addr,
    output logic [DATA_W-1:0]   phy_wdata,
    input  logic                phy_ack,
    input  logic [DATA_W-1:0]   phy_rdata,
    output logic                busy,
    output logic                done,
    output logic                dll_err
);

    localparam int SLOT_W = MODE_W + CLKSEL_W + DRV_W;

    typedef enum logic [3:0] {
        S_IDLE, S_MODE, S_PAD_RD, S_PAD_WR, S_OTAP, S_ITAP,
        S_TRIM, S_DLL_OFF, S_DLL_ON, S_POLL, S_FINISH
    } state_e;

    state_e state, nxt;

    logic                slot_valid, pop;
    logic [SLOT_W-1:0]   slot_data;
    logic [MODE_W-1:0]   slot_mode;
    logic [CLKSEL_W-1:0] slot_clk;
    logic [DRV_W-1:0]    slot_drv;
    mode_cfg_t           tbl_cfg, cur_cfg;
    logic                tbl_known, skip, expired;
    logic [CLKSEL_W-1:0] last_clk;
    logic                last_valid;
    logic [DRV_W-1:0]    cur_drv;
    logic [2:0]          cur_fs;
    logic [DATA_W-1:0]   pad_q;
    logic                err_q;

    phycfg_req_slot #(.W(SLOT_W)) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (req_valid),
        .din   ({req_mode, req_clksel, req_drive}),
        .pop   (pop),
        .valid (slot_valid),
        .dout  (slot_data)
    );

    assign {slot_mode, slot_clk, slot_drv} = slot_data;

    phycfg_mode_table u_table (
        .mode  (slot_mode),
        .cfg   (tbl_cfg),
        .known (tbl_known)
    );

    phycfg_poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == S_POLL),
        .expired (expired)
    );

    assign skip = last_valid && (slot_clk == last_clk);

    // Next state, slot pop and the PHY access presented in each state.
    always_comb begin
        nxt       = state;
        pop       = 1'b0;
        phy_req   = 1'b0;
        phy_wr    = 1'b1;
        phy_addr  = '0;
        phy_wdata = '0;
        case (state)
            S_IDLE: begin
                pop = slot_valid;
                if (slot_valid && !skip && tbl_known) nxt = S_MODE;
            end
            S_MODE: begin
                phy_req = 1'b1; phy_addr = A_MODE; phy_wdata = cur_cfg.mode_word;
                if (phy_ack) nxt = cur_cfg.pad_adj ? S_PAD_RD : S_OTAP;
            end
            S_PAD_RD: begin
                phy_req = 1'b1; phy_wr = 1'b0; phy_addr = A_PAD;
                if (phy_ack) nxt = S_PAD_WR;
            end
            S_PAD_WR: begin
                phy_req = 1'b1; phy_addr = A_PAD;
                phy_wdata = pad_q | (DATA_W'(cur_drv) << DRV_SHIFT);
                if (phy_ack) nxt = S_OTAP;
            end
            S_OTAP: begin
                phy_req = 1'b1; phy_addr = A_OTAP;
                phy_wdata = cur_cfg.otap_en ? {cur_cfg.otap, 1'b1} : '0;
                if (phy_ack) nxt = S_ITAP;
            end
            S_ITAP: begin
                phy_req = 1'b1; phy_addr = A_ITAP;
                phy_wdata = cur_cfg.itap_en ? {cur_cfg.itap, 1'b1} : '0;
                if (phy_ack) nxt = cur_cfg.dll_used ? S_TRIM : S_DLL_OFF;
            end
            S_TRIM: begin
                phy_req = 1'b1; phy_addr = A_TRIM; phy_wdata = TRIM_WORD;
                if (phy_ack) nxt = S_DLL_OFF;
            end
            S_DLL_OFF: begin
                phy_req = 1'b1; phy_addr = A_DLL;
                if (phy_ack) nxt = cur_cfg.dll_used ? S_DLL_ON : S_FINISH;
            end
            S_DLL_ON: begin
                phy_req = 1'b1; phy_addr = A_DLL;
                phy_wdata = {cur_fs, 5'b0} | DLL_ON;
                if (phy_ack) nxt = S_POLL;
            end
            S_POLL: begin
                phy_req = 1'b1; phy_wr = 1'b0; phy_addr = A_DLL;
                if (phy_ack && (phy_rdata[RDY_BIT] || expired)) nxt = S_FINISH;
            end
            S_FINISH: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Capture the request context, the pad readback and the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_cfg    <= '0;
            cur_drv    <= '0;
            cur_fs     <= '0;
            last_clk   <= '0;
            last_valid <= 1'b0;
            pad_q      <= '0;
            err_q      <= 1'b0;
        end else begin
            if (state == S_IDLE && slot_valid && !skip) begin
                last_clk   <= slot_clk;
                last_valid <= 1'b1;
                if (tbl_known) begin
                    cur_cfg <= tbl_cfg;
                    cur_drv <= slot_drv;
                    cur_fs  <= freqsel(slot_clk);
                    err_q   <= 1'b0;
                end
            end
            if (state == S_PAD_RD && phy_ack) pad_q <= phy_rdata;
            if (state == S_POLL && phy_ack && !phy_rdata[RDY_BIT] && expired)
                err_q <= 1'b1;
        end
    end

    assign busy    = (state != S_IDLE) || slot_valid;
    assign done    = (state == S_FINISH);
    assign dll_err = err_q;

endmodule

// File: rtl/phycfg_checker.sv
// Module: protocol and sequencing properties for phy_speed_sequencer,
// attached by bind. Observes the top-level ports only.
module phycfg_checker
    import phycfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              phy_req,
    input logic              phy_wr,
    input logic [ADDR_W-1:0] phy_addr,
    input logic [DATA_W-1:0] phy_wdata,
    input logic              phy_ack,
    input logic              busy,
    input logic              done,
    input logic              dll_err
);

    assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && !phy_ack) |=> (phy_req && $stable(phy_addr)
                                   && $stable(phy_wr) && $stable(phy_wdata)));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !phy_req);

    assert_done_ends_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && !phy_req));

    assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dll_err) |-> done);

    assert_err_clear_at_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dll_err) |-> (phy_req && phy_wr && phy_addr == A_MODE));

endmodule

bind phy_speed_sequencer phycfg_checker u_phycfg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .phy_req   (phy_req),
    .phy_wr    (phy_wr),
    .phy_addr  (phy_addr),
    .phy_wdata (phy_wdata),
    .phy_ack   (phy_ack),
    .busy      (busy),
    .done      (done),
    .dll_err   (dll_err)
);

// File: tb/phy_speed_sequencer_test.sv
// Bench: directed scenarios for phy_speed_sequencer. A register-bridge model
// acknowledges each access at a falling edge and logs it; every scenario
// task builds its expected access list from the requirement tables.
module phy_speed_sequencer_test;

    localparam int       CLK_P    = 10;
    localparam int       DRV_W    = 2;
    localparam logic [7:0] PAD_INIT = 8'h42;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_mode = '0;
    logic [1:0] req_clksel = '0;
    logic [DRV_W-1:0] req_drive = '0;
    logic       phy_req, phy_wr;
    logic [7:0] phy_addr, phy_wdata;
    logic       phy_ack = 1'b0;
    logic [7:0] phy_rdata = '0;
    logic       busy, done, dll_err;

    int checks = 0;
    int fails  = 0;

    // Bridge model state and access log.
    int         ready_after = 0;
    int         poll_n = 0;
    int         acc_n = 0;
    int         log_n = 0;
    logic [7:0] log_addr [32];
    logic       log_wr   [32];
    logic [7:0] log_data [32];

    int         exp_n = 0;
    logic [7:0] exp_addr [16];
    logic       exp_wr   [16];
    logic [7:0] exp_data [16];

    phy_speed_sequencer #(.POLL_LIMIT(64), .DRV_W(DRV_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_clksel(req_clksel), .req_drive(req_drive), .phy_req(phy_req),
        .phy_wr(phy_wr), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
        .phy_ack(phy_ack), .phy_rdata(phy_rdata), .busy(busy), .done(done),
        .dll_err(dll_err)
    );

    always #(CLK_P/2) clk = ~clk;

    // Bridge model: one acknowledge per access, DLL status after N polls.
    always @(negedge clk) begin
        if (phy_req && !phy_ack) begin
            phy_ack = 1'b1;
            acc_n++;
            if (!phy_wr && phy_addr == 8'h00) begin
                poll_n++;
                phy_rdata = (ready_after != 0 && poll_n >= ready_after) ? 8'h10 : 8'h00;
            end else begin
                if (!phy_wr) phy_rdata = PAD_INIT;
                if (log_n < 32) begin
                    log_addr[log_n] = phy_addr;
                    log_wr[log_n]   = phy_wr;
                    log_data[log_n] = phy_wdata;
                end
                log_n++;
            end
        end else begin
            phy_ack = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    task automatic push_exp(input logic [7:0] a, input logic w, input logic [7:0] d);
        exp_addr[exp_n] = a; exp_wr[exp_n] = w; exp_data[exp_n] = d;
        exp_n++;
    endtask

    // Expected access list (DLL status polls excluded), from R2..R7.
    task automatic build_exp(input int mode, input int clkc, input int drv);
        logic [7:0] mw, ot, it, fsw;
        exp_n = 0;
        case (mode)
            0: begin mw = 8'h04; ot = 8'h00; it = 8'h00; end
            1: begin mw = 8'h00; ot = 8'h07; it = 8'h05; end
            2: begin mw = 8'h00; ot = 8'h05; it = 8'h00; end
            3: begin mw = 8'h08; ot = 8'h03; it = 8'h01; end
            4: begin mw = 8'h02; ot = 8'h03; it = 8'h15; end
            default: begin mw = 8'h01; ot = 8'h03; it = 8'h01; end
        endcase
        case (clkc)
            1: fsw = 8'h48;
            2: fsw = 8'h28;
            default: fsw = 8'h08;
        endcase
        push_exp(8'h11, 1'b1, mw);
        if (mode == 2 || mode == 4) begin
            push_exp(8'h01, 1'b0, 8'h00);
            push_exp(8'h01, 1'b1, PAD_INIT | 8'(drv << 2));
        end
        push_exp(8'h0D, 1'b1, ot);
        push_exp(8'h0C, 1'b1, it);
        if (mode != 0) push_exp(8'h12, 1'b1, 8'h08);
        push_exp(8'h00, 1'b1, 8'h00);
        if (mode != 0) push_exp(8'h00, 1'b1, fsw);
    endtask

    task automatic compare_log(input string tag);
        check(log_n == exp_n, "R13", {tag, " access count"}, log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            string rq;
            case (exp_addr[i])
                8'h11: rq = "R2";
                8'h01: rq = "R3";
                8'h0D: rq = "R4";
                8'h0C: rq = "R5";
                8'h12: rq = "R6";
                default: rq = "R7";
            endcase
            check(log_addr[i] == exp_addr[i] && log_wr[i] == exp_wr[i], rq,
                  {tag, " access address/dir"}, {log_wr[i], log_addr[i]},
                  {exp_wr[i], exp_addr[i]});
            if (exp_wr[i])
                check(log_data[i] == exp_data[i], rq, {tag, " write data"},
                      log_data[i], exp_data[i]);
        end
    endtask

    task automatic clear_log();
        log_n = 0; poll_n = 0; acc_n = 0;
    endtask

    task automatic send_req(input int mode, input int clkc, input int drv);
        req_mode = 3'(mode); req_clksel = 2'(clkc); req_drive = DRV_W'(drv);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input int limit, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (done) begin seen = 1'b1; break; end
        end
    endtask

    // Full sequence for one mode with DLL ready on the given poll.
    task automatic run_mode(input int mode, input int clkc, input int drv,
                            input int rdy, input string tag);
        bit seen;
        @(negedge clk);
        clear_log();
        ready_after = rdy;
        send_req(mode, clkc, drv);
        check(busy == 1'b1, "R1", {tag, " busy after strobe"}, busy, 1);
        wait_done(400, seen);
        check(seen, "R1", {tag, " done pulse"}, seen, 1);
        check(dll_err == 1'b0, "R8", {tag, " no error"}, dll_err, 0);
        build_exp(mode, clkc, drv);
        compare_log(tag);
        check(poll_n == ((mode == 0) ? 0 : rdy), "R8", {tag, " poll count"},
              poll_n, (mode == 0) ? 0 : rdy);
        @(negedge clk);
        check(busy == 1'b0, "R1", {tag, " idle after done"}, busy, 0);
    endtask

    // Quiet window: no PHY access and no done for a request that must be dropped.
    task automatic expect_dropped(input int mode, input int clkc, input string rq,
                                  input string tag);
        int dn = 0;
        @(negedge clk);
        clear_log();
        send_req(mode, clkc, 0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (done) dn++;
        end
        check(acc_n == 0, rq, {tag, " no PHY access"}, acc_n, 0);
        check(dn == 0, rq, {tag, " no done"}, dn, 0);
        check(busy == 1'b0, rq, {tag, " back to idle"}, busy, 0);
    endtask

    task automatic test_reset();
        check(!busy && !done && !phy_req && !dll_err, "R14", "reset outputs",
              {busy, done, phy_req, dll_err}, 0);
    endtask

    task automatic test_timeout();
        bit seen;
        int after = 0;
        @(negedge clk);
        clear_log();
        ready_after = 0;
        send_req(1, 0, 0);
        wait_done(400, seen);
        check(seen, "R9", "timeout done", seen, 1);
        check(dll_err == 1'b1, "R9", "timeout error flag", dll_err, 1);
        check(poll_n > 1, "R9", "polled repeatedly", poll_n, 2);
        clear_log();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (phy_req) after++;
        end
        check(after == 0 && acc_n == 0, "R9", "no retry", after, 0);
        check(dll_err == 1'b1, "R9", "error held", dll_err, 1);
    endtask

    task automatic test_latch();
        bit seen;
        @(negedge clk);
        clear_log();
        ready_after = 1;
        send_req(3, 1, 0);
        repeat (3) @(negedge clk);
        send_req(4, 3, 1);
        send_req(5, 2, 0);
        wait_done(400, seen);
        check(seen, "R11", "first done", seen, 1);
        check(dll_err == 1'b0, "R9", "error cleared by new sequence", dll_err, 1'b0);
        build_exp(3, 1, 0);
        compare_log("R11 first");
        clear_log();
        wait_done(400, seen);
        check(seen, "R11", "waiting request ran", seen, 1);
        build_exp(5, 2, 0);
        compare_log("R11 latest");
        @(negedge clk);
        check(busy == 1'b0, "R11", "idle after waiting request", busy, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_mode(1, 0, 0, 2, "R2 high speed");
        run_mode(2, 1, 2, 1, "R3 HS200");
        run_mode(4, 2, 3, 3, "R5 HS400");
        run_mode(3, 3, 0, 1, "R7 DDR50");
        run_mode(5, 0, 0, 2, "R4 strobe");
        run_mode(0, 1, 0, 1, "R6 legacy");
        expect_dropped(1, 1, "R10", "R10 same clock");
        expect_dropped(6, 2, "R12", "R12 code 6");
        expect_dropped(1, 2, "R12", "R12 clock recorded");
        test_timeout();
        test_latch();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule